// File: doc/BRIEF.md
# Keyed Write-Enable Unlock Sequencer

This block owns the single bit that permits writes to a set of time-keeping registers. Software cannot set the bit with an ordinary register write. It must first store the word 0x0055 to a key register and let exactly one other instruction retire. It must then store 0x0AA to the same key register. The very next instruction must be a configuration write that carries a one in the enable position. If the ordering, the spacing or the key value is wrong, or the set arrives late, the attempt is discarded. The bit stays clear.

Time is counted in instruction slots, not clock cycles. A slot is any cycle in which `instr_tick` is high, and a register write only takes effect when its strobe coincides with a slot. The sequencer has four states:

- **IDLE**: no key has been seen.
- **KEY1**: the first key has arrived.
- **GAP**: the separating instruction has retired.
- **OPEN**: the one-slot window for the set is open.

The transitions are:

- **start**: IDLE to KEY1 on the first key.
- **restart**: any state to KEY1 on the first key.
- **spacer**: KEY1 to GAP on any non-key instruction.
- **abort**: to IDLE on a wrong key, a missing or extra spacer, or any other instruction.
- **arm**: GAP to OPEN on the second key.
- **expire**: OPEN to IDLE after one slot.

Clearing the bit needs no unlock. A timer-register write is granted only while the bit is set.

Top module: `ukey_unlock`

## Requirements
- R1: Reset forces the enable output low and the sequencer to idle, so a configuration set written right after reset leaves the enable low.
- R2: The enable output goes high one clock after a configuration write (address 0x20) with bit 13 set, when that write falls in the slot after this sequence: key register (address 0x10) written with 0x0055, exactly one other instruction, key register written with 0x00AA. The spacing instruction may be a write to another address.
- R3: If 0x00AA is written in the slot directly after 0x0055, the attempt fails and a following set is ignored.
- R4: Two or more instructions between the two key writes make the attempt fail.
- R5: Keys in reverse order, or a second key of any value other than 0x00AA, make the attempt fail.
- R6: A set write that arrives one slot or more after the second key is ignored.
- R7: A configuration write with bit 13 clear drives the enable low one clock later, in any state, without an unlock.
- R8: Cycles with `instr_tick` low neither advance nor expire the sequence, and a write strobe without `instr_tick` has no effect.
- R9: `tmr_wr_ok_o` is high only in a slot with a write to the timer addresses 0x30 to 0x33 while the enable is set; otherwise it is low.
- R10: A repeated 0x0055 key write restarts the sequence, so a correct completion after it still sets the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_tick | input | 1 | High in a cycle where one instruction retires |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| wen_o | output | 1 | Write-enable bit for the time-keeping registers |
| tmr_wr_ok_o | output | 1 | Write to a timer register is granted this cycle |

## Verification
The main function is driven with these patterns:

- the correct key pair with one spacer, where the spacer is both a no-op and a blocked timer write;
- no spacer, and two spacers, which separate a correct gap count from an off-by-one;
- reversed keys and a corrupt second key, which show that both the value and the order are decoded;
- a set one slot late, which shows that the window closes after a single slot;
- the whole sequence stretched with idle clock cycles, which shows that slots are counted rather than clocks;
- a doubled first key, which exposes a sequencer that does not restart.

Clear writes, with and without a slot, and timer writes just inside and just outside the range bound the grant and the clear.

// File: rtl/ukey_pkg.sv
package ukey_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY1 = 2'd1,
        ST_GAP  = 2'd2,
        ST_OPEN = 2'd3
    } useq_state_t;

endpackage

// File: rtl/ukey_decode.sv
module ukey_decode #(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 16,
    parameter logic [ADDR_W-1:0]    KEY_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0]    CFG_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0]    TMR_BASE  = 8'h30,
    parameter int unsigned          TMR_COUNT = 4,
    parameter int unsigned          EN_BIT    = 13,
    parameter logic [DATA_W-1:0]    KEY_FIRST = 16'h0055,
    parameter logic [DATA_W-1:0]    KEY_SECOND = 16'h00AA
) (
    input  logic              instr_tick,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              slot,
    output logic              key_first,
    output logic              key_second,
    output logic              key_other,
    output logic              cfg_set,
    output logic              cfg_clr,
    output logic              tmr_hit
);

    logic                 wr_live;
    logic                 key_wr;
    logic                 cfg_wr;
    logic [TMR_COUNT-1:0] tmr_match;

    assign slot    = instr_tick;
    assign wr_live = instr_tick & wr_stb;
    assign key_wr  = wr_live & (wr_addr == KEY_ADDR);
    assign cfg_wr  = wr_live & (wr_addr == CFG_ADDR);

    assign key_first  = key_wr & (wr_data == KEY_FIRST);
    assign key_second = key_wr & (wr_data == KEY_SECOND);
    assign key_other  = key_wr & ~key_first & ~key_second;

    assign cfg_set = cfg_wr &  wr_data[EN_BIT];
    assign cfg_clr = cfg_wr & ~wr_data[EN_BIT];

    for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
        assign tmr_match[g] = (wr_addr == TMR_BASE + ADDR_W'(g));
    end

    assign tmr_hit = wr_live & (|tmr_match);

endmodule

// File: rtl/ukey_fsm.sv
module ukey_fsm
    import ukey_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slot,
    input  logic        key_first,
    input  logic        key_second,
    input  logic        key_other,
    output useq_state_t state_q,
    output logic        window_open
);

    useq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (slot) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (key_first) state_d = ST_KEY1;
                end
                ST_KEY1: begin
                    if (key_first)                    state_d = ST_KEY1;
                    else if (key_second || key_other) state_d = ST_IDLE;
                    else                              state_d = ST_GAP;
                end
                ST_GAP: begin
                    if (key_second)     state_d = ST_OPEN;
                    else if (key_first) state_d = ST_KEY1;
                    else                state_d = ST_IDLE;
                end
                ST_OPEN: begin
                    if (key_first) state_d = ST_KEY1;
                    else           state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        window_open = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/ukey_enable.sv
module ukey_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic window_open,
    input  logic cfg_set,
    input  logic cfg_clr,
    output logic en_q
);

    logic en_d;

    always_comb begin
        en_d = en_q;
        if (cfg_clr) begin
            en_d = 1'b0;
        end else if (cfg_set && window_open) begin
            en_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/ukey_unlock.sv
module ukey_unlock
    import ukey_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned TMR_COUNT = 4,
    parameter int unsigned EN_BIT    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_tick,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wen_o,
    output logic              tmr_wr_ok_o
);

    logic        slot;
    logic        key_first;
    logic        key_second;
    logic        key_other;
    logic        cfg_set;
    logic        cfg_clr;
    logic        tmr_hit;
    logic        window_open;
    useq_state_t state_q;

    ukey_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .KEY_ADDR  (ADDR_W'(8'h10)),
        .CFG_ADDR  (ADDR_W'(8'h20)),
        .TMR_BASE  (ADDR_W'(8'h30)),
        .TMR_COUNT (TMR_COUNT),
        .EN_BIT    (EN_BIT),
        .KEY_FIRST (DATA_W'(8'h55)),
        .KEY_SECOND(DATA_W'(8'hAA))
    ) u_decode (
        .instr_tick(instr_tick),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .slot      (slot),
        .key_first (key_first),
        .key_second(key_second),
        .key_other (key_other),
        .cfg_set   (cfg_set),
        .cfg_clr   (cfg_clr),
        .tmr_hit   (tmr_hit)
    );

    ukey_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .key_first  (key_first),
        .key_second (key_second),
        .key_other  (key_other),
        .state_q    (state_q),
        .window_open(window_open)
    );

    ukey_enable u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .window_open(window_open),
        .cfg_set    (cfg_set),
        .cfg_clr    (cfg_clr),
        .en_q       (wen_o)
    );

    assign tmr_wr_ok_o = tmr_hit & wen_o;

endmodule

// File: rtl/ukey_unlock_chk.sv
module ukey_unlock_chk
    import ukey_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        instr_tick,
    input logic        wr_stb,
    input useq_state_t state_q,
    input logic        key_second,
    input logic        cfg_set,
    input logic        cfg_clr,
    input logic        wen,
    input logic        grant
);

    // R2: the enable can only rise out of a set written in the open window
    a_r2_rise_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen) |-> $past(state_q == ST_OPEN && cfg_set));

    // R3: a second key with no spacer ends in idle, not in the window
    a_r3_no_gap_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY1 && key_second) |=> (state_q == ST_IDLE));

    // R6: the window lasts one slot only
    a_r6_window_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && instr_tick) |=> (state_q != ST_OPEN));

    // R7: a clear write drops the enable
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> !wen);

    // R8: no slot, no progress
    a_r8_hold_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_tick |=> ($stable(state_q) && $stable(wen)));

    // R9: a grant needs a live write slot and the enable
    a_r9_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (wen && wr_stb && instr_tick));

endmodule

bind ukey_unlock ukey_unlock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_tick(instr_tick),
    .wr_stb    (wr_stb),
    .state_q   (state_q),
    .key_second(key_second),
    .cfg_set   (cfg_set),
    .cfg_clr   (cfg_clr),
    .wen       (wen_o),
    .grant     (tmr_wr_ok_o)
);

// File: tb/ukey_unlock_test.sv
module ukey_unlock_test;

    logic        clk;
    logic        rst_n;
    logic        instr_tick;
    logic        wr_stb;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wen_o;
    logic        tmr_wr_ok_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    ukey_unlock uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_tick (instr_tick),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wen_o      (wen_o),
        .tmr_wr_ok_o(tmr_wr_ok_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    localparam logic [7:0]  AK = 8'h10;   // key register
    localparam logic [7:0]  AC = 8'h20;   // configuration register
    localparam logic [15:0] SET = 16'h2000;
    localparam logic [15:0] CLR = 16'h0000;
    localparam logic [15:0] K1 = 16'h0055;
    localparam logic [15:0] K2 = 16'h00AA;
    localparam int NV = 48;

    // {req[3:0], tick, wr, addr[7:0], data[15:0], exp_en_after, exp_grant}
    localparam logic [31:0] VEC [0:NV-1] = '{
        {4'd1,  1'b1, 1'b1, AC,    SET,      1'b0, 1'b0}, // R1 set with no unlock
        {4'd9,  1'b1, 1'b1, 8'h30, 16'h1111, 1'b0, 1'b0}, // R9 timer write locked
        {4'd2,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R2 first key
        {4'd2,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R2 spacer
        {4'd2,  1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R2 second key
        {4'd2,  1'b1, 1'b1, AC,    SET,      1'b1, 1'b0}, // R2 set in window
        {4'd9,  1'b1, 1'b1, 8'h31, 16'h1234, 1'b1, 1'b1}, // R9 granted
        {4'd9,  1'b1, 1'b1, 8'h33, 16'h0001, 1'b1, 1'b1}, // R9 top of range
        {4'd9,  1'b1, 1'b1, 8'h34, 16'h0001, 1'b1, 1'b0}, // R9 outside range
        {4'd7,  1'b1, 1'b1, AC,    CLR,      1'b0, 1'b0}, // R7 clear
        {4'd3,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R3
        {4'd3,  1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R3 no spacer
        {4'd3,  1'b1, 1'b1, AC,    SET,      1'b0, 1'b0}, // R3 set ignored
        {4'd4,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R4
        {4'd4,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R4
        {4'd4,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R4 extra spacer
        {4'd4,  1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R4
        {4'd4,  1'b1, 1'b1, AC,    SET,      1'b0, 1'b0}, // R4 set ignored
        {4'd5,  1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R5 reversed
        {4'd5,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R5
        {4'd5,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R5
        {4'd5,  1'b1, 1'b1, AC,    SET,      1'b0, 1'b0}, // R5 set ignored
        {4'd5,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R5 settle
        {4'd5,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R5
        {4'd5,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R5
        {4'd5,  1'b1, 1'b1, AK,    16'h00A5, 1'b0, 1'b0}, // R5 bad value
        {4'd5,  1'b1, 1'b1, AC,    SET,      1'b0, 1'b0}, // R5 set ignored
        {4'd6,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R6
        {4'd6,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R6
        {4'd6,  1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R6
        {4'd6,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R6 window lost
        {4'd6,  1'b1, 1'b1, AC,    SET,      1'b0, 1'b0}, // R6 late set
        {4'd8,  1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R8
        {4'd8,  1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R8 idle clock
        {4'd8,  1'b0, 1'b1, AK,    K2,       1'b0, 1'b0}, // R8 strobe w/o slot
        {4'd8,  1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R8 spacer
        {4'd8,  1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R8 idle clock
        {4'd8,  1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R8 second key
        {4'd8,  1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0}, // R8 window kept
        {4'd8,  1'b1, 1'b1, AC,    SET,      1'b1, 1'b0}, // R8 set lands
        {4'd8,  1'b0, 1'b1, 8'h30, 16'h0001, 1'b1, 1'b0}, // R8 no grant w/o slot
        {4'd7,  1'b0, 1'b1, AC,    CLR,      1'b1, 1'b0}, // R7 clear w/o slot
        {4'd7,  1'b1, 1'b1, AC,    CLR,      1'b0, 1'b0}, // R7 clear
        {4'd10, 1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R10
        {4'd10, 1'b1, 1'b1, AK,    K1,       1'b0, 1'b0}, // R10 restart
        {4'd10, 1'b1, 1'b1, 8'h32, 16'h0007, 1'b0, 1'b0}, // R10 spacer is a blocked write
        {4'd10, 1'b1, 1'b1, AK,    K2,       1'b0, 1'b0}, // R10
        {4'd10, 1'b1, 1'b1, AC,    SET,      1'b1, 1'b0}  // R10 set lands
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // drive one cycle, check grant mid-cycle and enable after the edge
    task automatic step(input logic t, input logic w, input logic [7:0] a, input logic [15:0] d,
                        input logic exp_en, input logic exp_gr, input string req);
        @(negedge clk);
        instr_tick = t; wr_stb = w; wr_addr = a; wr_data = d;
        #2;
        check(req, tmr_wr_ok_o, exp_gr, "grant");
        @(posedge clk);
        #2;
        check(req, wen_o, exp_en, "enable");
        instr_tick = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R1", wen_o, 1'b0, "enable in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; instr_tick = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1", wen_o, 1'b0, "reset value");
        check("R1", tmr_wr_ok_o, 1'b0, "reset grant");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][27], VEC[i][26], VEC[i][25:18], VEC[i][17:2],
                 VEC[i][1], VEC[i][0], $sformatf("R%0d", VEC[i][31:28]));
        end

        // R1: reset while enabled clears the bit
        do_reset();
        step(1'b1, 1'b1, AK, K1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 8'h00, 16'h0, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, AK, K2, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b1, AC, SET, 1'b1, 1'b0, "R2");
        do_reset();
        step(1'b1, 1'b1, 8'h30, 16'h5, 1'b0, 1'b0, "R1");

        // R1: reset in the open window returns to idle
        step(1'b1, 1'b1, AK, K1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 8'h00, 16'h0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, AK, K2, 1'b0, 1'b0, "R1");
        do_reset();
        step(1'b1, 1'b1, AC, SET, 1'b0, 1'b0, "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule